// File: doc/BRIEF.md
# Time-of-Day Alarm Match Unit

This block sits beside a real-time clock core and watches the running time for one programmed instant. Software loads a target second, minute, hour and day of month, all in BCD, through a small register bus. Each time the clock core pulses its once-per-second update strobe, the block compares the live time fields with the targets. When all four agree, it latches an alarm status flag.

The flag can raise an interrupt through two enables. One enable applies while the system runs from main power. The other applies while a battery-backup input says the system runs on its reserve supply. Software reads the flag register to learn that the alarm happened. That read clears the flag, so no separate acknowledge write is needed. While the target registers are being rewritten, software clears both enables so that a half-written target cannot raise an interrupt.

Top module: `tod_alarm_match`

## Requirements
- R1: After a synchronous active-low reset, every register reads as zero and `irq` is low.
- R2: Register selects 0, 1, 2 and 3 hold the alarm second, minute, hour and day of month. A write stores the data and a read returns it. Second and minute keep bits 6:0, hour and day keep bits 5:0, and the upper bits read as zero.
- R3: The alarm flag sets only in a cycle where `tick` is high and all four live fields equal their alarm registers, compared over the kept bits. Without a strobe, or with any one field different, the flag stays clear.
- R4: A match sets the flag (select 5, bit 0) from the next cycle on, whatever the enables hold.
- R5: A read of select 5 returns the flag in the same cycle through combinational read data. From the next cycle on the flag is clear.
- R6: The enables register is select 4, with bit 0 as the interrupt enable and bit 1 as the battery enable. With `on_battery` low, `irq` is high exactly when the flag and bit 0 are both 1. It falls in the cycle after a clearing read.
- R7: With `on_battery` high, `irq` is high exactly when the flag and bit 1 are both 1, and bit 0 has no effect.
- R8: When a read of select 5 and a match fall in the same cycle, the flag is 1 afterwards.
- R9: Writes to select 5 leave the flag unchanged. Selects 6 and 7 read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle once-per-second update strobe from the clock core |
| cur_sec | input | 8 | Live seconds, BCD |
| cur_min | input | 8 | Live minutes, BCD |
| cur_hour | input | 8 | Live hours, BCD |
| cur_mday | input | 8 | Live day of month, BCD |
| on_battery | input | 1 | High while the system runs on its backup supply |
| reg_sel | input | 3 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (a read of select 5 clears the flag) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for `reg_sel` |
| irq | output | 1 | Active-high alarm interrupt |

## Verification
The hardest case to reach from the ports is a clearing read of the flag register landing in the same cycle as a matching strobe. In that case the set must win. The stimulus builds it by first holding the live time equal to the target, then raising `reg_rd` on select 5 together with `tick`. A second read then shows whether the event survived. Battery gating is reached by toggling `on_battery` while the flag is held set and the two enable bits are swapped, so that each combination shows up on `irq` without a new match.

// File: rtl/tam_pkg.sv
// Shared constants for the alarm match unit: register selects, bit
// positions and the per-field masks of kept BCD bits.
// Assumes an 8-bit data bus and four compared time fields.
package tam_pkg;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 3;
    localparam int NFIELD  = 4;
    localparam int EN_W    = 2;

    localparam logic [ADDR_W-1:0] SEL_ENABLE = 3'd4;
    localparam logic [ADDR_W-1:0] SEL_FLAGS  = 3'd5;

    localparam int EN_INT_BIT  = 0;
    localparam int EN_BATT_BIT = 1;

    // Kept bits of each field: 0 second, 1 minute, 2 hour, 3 day.
    function automatic logic [DATA_W-1:0] field_mask(input int idx);
        return (idx < 2) ? 8'h7F : 8'h3F;
    endfunction
endpackage

// File: rtl/tam_regfile.sv
// Alarm target and enables storage for the alarm match unit.
// Holds one masked register per compared field plus the enables register.
// Assumes single-cycle write strobes and a synchronous active-low reset.
module tam_regfile
    import tam_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             sel,
    input  logic [DATA_W-1:0]             wdata,
    output logic [NFIELD-1:0][DATA_W-1:0] alarm_q,
    output logic [EN_W-1:0]               enables_q
);
    genvar i;
    generate
        for (i = 0; i < NFIELD; i++) begin : g_field
            // Store the kept bits of one alarm field on a write to its select.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    alarm_q[i] <= '0;
                else if (wr_en && sel == ADDR_W'(i))
                    alarm_q[i] <= wdata & field_mask(i);
            end
        end
    endgenerate

    // Store the two enable bits on a write to the enables select.
    always_ff @(posedge clk) begin
        if (!rst_n)
            enables_q <= '0;
        else if (wr_en && sel == SEL_ENABLE)
            enables_q <= wdata[EN_W-1:0];
    end
endmodule

// File: rtl/tam_compare.sv
// Field-by-field equality between the live time and the alarm targets.
// Compares only the kept bits of each field; purely combinational.
module tam_compare
    import tam_pkg::*;
(
    input  logic [NFIELD-1:0][DATA_W-1:0] live,
    input  logic [NFIELD-1:0][DATA_W-1:0] target,
    output logic                          match
);
    logic [NFIELD-1:0] eq;

    genvar i;
    generate
        for (i = 0; i < NFIELD; i++) begin : g_eq
            // One field equal over its kept bits.
            assign eq[i] = ((live[i] & field_mask(i)) == target[i]);
        end
    endgenerate

    // Every field must agree.
    assign match = &eq;
endmodule

// File: rtl/tam_flag.sv
// Alarm status flag with clear-on-read.
// A match strobe outranks a clearing read in the same cycle, so no event is lost.
module tam_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic clr_rd,
    output logic flag_q
);
    // Set on match, clear on read, set wins when both occur together.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (set_ev)
            flag_q <= 1'b1;
        else if (clr_rd)
            flag_q <= 1'b0;
    end
endmodule

// File: rtl/tod_alarm_match.sv
// Top of the alarm match unit: register bus, once-per-second comparison,
// clear-on-read status flag and power-mode gated interrupt.
// Assumes the live BCD fields are stable whenever tick is high.
module tod_alarm_match
    import tam_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [7:0]        cur_sec,
    input  logic [7:0]        cur_min,
    input  logic [7:0]        cur_hour,
    input  logic [7:0]        cur_mday,
    input  logic              on_battery,
    input  logic [2:0]        reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              irq
);
    logic [NFIELD-1:0][DATA_W-1:0] live;
    logic [NFIELD-1:0][DATA_W-1:0] alarm_q;
    logic [EN_W-1:0]               enables;
    logic                          hit;
    logic                          rd_flags;
    logic                          alarm_flag;

    // Gather the live fields in select order.
    assign live = {cur_mday, cur_hour, cur_min, cur_sec};

    tam_regfile u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr),
        .sel       (reg_sel),
        .wdata     (reg_wdata),
        .alarm_q   (alarm_q),
        .enables_q (enables)
    );

    tam_compare u_cmp (
        .live   (live),
        .target (alarm_q),
        .match  (hit)
    );

    // A clearing read is any read strobe on the flags select.
    assign rd_flags = reg_rd && (reg_sel == SEL_FLAGS);

    tam_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_ev (tick && hit),
        .clr_rd (rd_flags),
        .flag_q (alarm_flag)
    );

    // Read data multiplexer for all selects.
    always_comb begin
        reg_rdata = '0;
        if (reg_sel < SEL_ENABLE)
            reg_rdata = alarm_q[reg_sel[1:0]];
        else if (reg_sel == SEL_ENABLE)
            reg_rdata = {{(DATA_W-EN_W){1'b0}}, enables};
        else if (reg_sel == SEL_FLAGS)
            reg_rdata = {{(DATA_W-1){1'b0}}, alarm_flag};
    end

    // Interrupt gated by the enable that belongs to the current power mode.
    assign irq = alarm_flag &&
                 (on_battery ? enables[EN_BATT_BIT] : enables[EN_INT_BIT]);
endmodule

// File: rtl/tam_alarm_checker.sv
// Temporal checks on the alarm match unit, bound to its top module.
module tam_alarm_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       match,
    input logic       rd_flags,
    input logic       flag,
    input logic       irq,
    input logic       on_battery,
    input logic [1:0] en
);
    AST_SET_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        tick && match |=> flag); // R4
    AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_flags && !(tick && match) |=> !flag); // R5
    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        !flag && !(tick && match) |=> !flag); // R3
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag); // R6
    AST_BATT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        on_battery && !en[1] |-> !irq); // R7
    AST_READ_MATCH_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_flags && tick && match |=> flag); // R8
endmodule

bind tod_alarm_match tam_alarm_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .match      (hit),
    .rd_flags   (rd_flags),
    .flag       (alarm_flag),
    .irq        (irq),
    .on_battery (on_battery),
    .en         (enables)
);

// File: tb/sim_tod_alarm_match.sv
module sim_tod_alarm_match;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] cur_sec = '0, cur_min = '0, cur_hour = '0, cur_mday = '0;
    logic       on_battery = 1'b0;
    logic [2:0] reg_sel = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] last_rd;

    tod_alarm_match u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
        .cur_mday(cur_mday), .on_battery(on_battery),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference state
    logic [7:0] m_al [4];
    logic [1:0] m_en;
    logic       m_flag;

    function automatic logic [7:0] keep(input int i);
        return (i < 2) ? 8'h7F : 8'h3F;
    endfunction

    function automatic logic [7:0] exp_rdata();
        case (reg_sel)
            3'd0, 3'd1, 3'd2, 3'd3: return m_al[int'(reg_sel)];
            3'd4: return {6'd0, m_en};
            3'd5: return {7'd0, m_flag};
            default: return 8'd0;
        endcase
    endfunction

    function automatic logic exp_irq();
        return m_flag && (on_battery ? m_en[1] : m_en[0]);
    endfunction

    // Reference model advanced on every clock edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) m_al[i] = 8'd0;
            m_en = 2'd0;
            m_flag = 1'b0;
        end else begin
            automatic logic hit = tick &&
                ((cur_sec  & 8'h7F) == m_al[0]) && ((cur_min  & 8'h7F) == m_al[1]) &&
                ((cur_hour & 8'h3F) == m_al[2]) && ((cur_mday & 8'h3F) == m_al[3]);
            automatic logic nf = m_flag;
            if (reg_rd && reg_sel == 3'd5) nf = 1'b0;
            if (hit) nf = 1'b1;
            if (reg_wr) begin
                if (reg_sel < 3'd4) m_al[int'(reg_sel)] = reg_wdata & keep(int'(reg_sel));
                else if (reg_sel == 3'd4) m_en = reg_wdata[1:0];
            end
            m_flag = nf;
        end
    end

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // Compare against the model mid-cycle, then move to the next falling edge.
    task automatic cyc(input string tag);
        #(CLK_PERIOD/4);
        last_rd = reg_rdata;
        if (rst_n) begin
            check({tag, " rdata"}, reg_rdata, exp_rdata());
            check({tag, " irq"}, {7'd0, irq}, {7'd0, exp_irq()});
        end
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] s, input logic [7:0] d, input string tag);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        cyc(tag);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] s, input string tag);
        reg_rd = 1'b1; reg_sel = s;
        cyc(tag);
        reg_rd = 1'b0;
    endtask

    task automatic sec_tick(input string tag);
        tick = 1'b1;
        cyc(tag);
        tick = 1'b0;
    endtask

    task automatic set_time(input logic [7:0] s, input logic [7:0] m,
                            input logic [7:0] h, input logic [7:0] d);
        cur_sec = s; cur_min = m; cur_hour = h; cur_mday = d;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        @(negedge clk);
        repeat (3) cyc("R1 reset");
        rst_n = 1'b1;
        // R1: reset state
        for (int s = 0; s < 8; s++) begin
            rd(3'(s), "R1 reset read");
            if (s != 5) check("R1 absolute zero", last_rd, 8'd0);
        end
        check("R1 irq low", {7'd0, irq}, 8'd0);

        // R2: alarm register storage and masking
        wr(3'd0, 8'hFF, "R2 write sec");
        reg_sel = 3'd0; cyc("R2 read sec");
        check("R2 sec mask", last_rd, 8'h7F);
        wr(3'd2, 8'hFF, "R2 write hour");
        reg_sel = 3'd2; cyc("R2 read hour");
        check("R2 hour mask", last_rd, 8'h3F);
        wr(3'd0, 8'h30, "R2 sec");
        wr(3'd1, 8'h45, "R2 min");
        wr(3'd2, 8'h12, "R2 hour");
        wr(3'd3, 8'h25, "R2 mday");
        reg_sel = 3'd3; cyc("R2 read mday");
        check("R2 mday value", last_rd, 8'h25);

        // R3: one field differs, and a match with no strobe
        set_time(8'h30, 8'h45, 8'h12, 8'h24);
        sec_tick("R3 day differs");
        rd(3'd5, "R3 flag after mismatch");
        check("R3 no flag on mismatch", last_rd, 8'd0);
        set_time(8'h30, 8'h45, 8'h12, 8'h25);
        repeat (3) cyc("R3 no strobe");
        rd(3'd5, "R3 flag without strobe");
        check("R3 no flag without strobe", last_rd, 8'd0);

        // R4/R5: match with enables off, then clear on read
        sec_tick("R4 match");
        check("R4 irq off with enables clear", {7'd0, irq}, 8'd0);
        rd(3'd5, "R5 read flag");
        check("R4 flag set", last_rd, 8'd1);
        rd(3'd5, "R5 second read");
        check("R5 flag cleared by read", last_rd, 8'd0);

        // R6: interrupt enable in main power mode
        wr(3'd4, 8'h01, "R6 enable int");
        sec_tick("R6 match");
        check("R6 irq high", {7'd0, irq}, 8'd1);
        rd(3'd5, "R6 clearing read");
        check("R6 irq drops after read", {7'd0, irq}, 8'd0);

        // R9: writes to the flags select are ignored; selects 6 and 7 inert
        sec_tick("R9 set flag");
        wr(3'd5, 8'h00, "R9 write flags");
        wr(3'd6, 8'hFF, "R9 write sel6");
        reg_sel = 3'd6; cyc("R9 read sel6");
        check("R9 sel6 reads zero", last_rd, 8'd0);
        rd(3'd5, "R9 flag survives write");
        check("R9 flag still set", last_rd, 8'd1);

        // R7: battery mode gating
        on_battery = 1'b1;
        sec_tick("R7 match on battery");
        check("R7 int enable ignored on battery", {7'd0, irq}, 8'd0);
        wr(3'd4, 8'h03, "R7 enable batt");
        check("R7 irq with batt enable", {7'd0, irq}, 8'd1);
        wr(3'd4, 8'h02, "R7 batt only");
        check("R7 batt enable alone", {7'd0, irq}, 8'd1);
        on_battery = 1'b0;
        cyc("R7 back on main power");
        check("R7 main power needs int enable", {7'd0, irq}, 8'd0);
        rd(3'd5, "R7 clear");

        // R8: clearing read coincides with a match
        reg_rd = 1'b1; reg_sel = 3'd5;
        sec_tick("R8 read plus match");
        reg_rd = 1'b0;
        rd(3'd5, "R8 flag kept");
        check("R8 event not lost", last_rd, 8'd1);
        sec_tick("R8 set again");
        reg_rd = 1'b1; reg_sel = 3'd5;
        sec_tick("R8 read plus match while set");
        reg_rd = 1'b0;
        rd(3'd5, "R8 flag kept while set");
        check("R8 flag still set", last_rd, 8'd1);

        repeat (2) cyc("R5 idle");
        summary();
    end
endmodule